// File: doc/BRIEF.md
# Indirect-Addressed Control Register File

This block is the host-facing configuration store of a multi-channel timing controller. A byte-wide host bus presents two kinds of write strobe: an address strobe that latches a byte as the current address, and a data strobe that delivers a byte to whatever that address means. A small set of reserved addresses act on their own as soon as they are addressed. One resets every register. One stops the controller and one restarts it. One more reserved address makes the next data byte a group pointer.

The group pointer chooses which stateful bank later data writes land in. It can name one of the per-channel banks or the single top-level bank. Every non-reserved address is then taken as an offset inside that bank. Each bank holds four 16-bit time values, built from separate low and high byte writes. Each channel bank also holds a 3-bit status field. All stored contents are driven out in parallel to the pulse generators. Configuration is accepted only while the controller is stopped. A data write made while it runs is refused and raises a sticky error flag.

Top module: `indir_regfile`

## Requirements
- R1: After `rst_n` is released, `paused` is 1, `errFlag` is 0, `activeGroup` is 0, and every time value and status bit is 0.
- R2: An address strobe carrying 135 clears, by the next clock edge, all channel and top-level time values, all status bits, `activeGroup` and `errFlag`, and sets `paused` to 1. No data byte is needed.
- R3: An address strobe carrying 23 sets `paused` to 1 and one carrying 31 clears it, each by the next clock edge, with no data byte.
- R4: While paused, a data strobe that follows an address strobe of 15 loads the data byte into `activeGroup`. Group values 0 to NUM_CH-1 select a channel bank and value 64 selects the top-level bank.
- R5: While paused with a channel bank selected, a data write at offset n (0 to 3) sets bits 7:0 of that channel's time value n, and a write at offset 128+n sets bits 15:8. No other register changes.
- R6: While paused with a channel bank selected, a data write at offset 4 stores data bits 2:0 into that channel's status field. Bit 0 is enable, bit 1 is polarity and bit 2 is fill skip. Data bits 7:3 are dropped.
- R7: With group 64 selected, writes at offsets 0 to 3 and 128 to 131 set the low and high bytes of top-level time value 0 to 3, and the channel banks are unchanged.
- R8: A data strobe while `paused` is 0 changes no register, including `activeGroup`, and sets `errFlag`. `errFlag` then stays 1 until a strobe of address 135 or `rst_n` clears it.
- R9: Data writes are discarded in three cases: an offset the selected bank does not implement, offset 4 in the top-level bank, or a group value that is neither below NUM_CH nor 64.
- R10: Addresses 135, 23 and 31 act the same whatever `activeGroup` holds. A data strobe whose latched address is one of them changes nothing. When both strobes are active in the same cycle, the data strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addrWr | input | 1 | Address strobe: latch `hostByte` as the current address |
| dataWr | input | 1 | Data strobe: write `hostByte` to the current address |
| hostByte | input | 8 | Host bus byte |
| chTime | output | NUM_CH*4*16 | Channel time values; channel c, value n at bits [(c*4+n)*16 +: 16] |
| chStatus | output | NUM_CH*3 | Channel status fields; channel c at bits [c*3 +: 3] |
| topTime | output | 4*16 | Top-level time values; value n at bits [n*16 +: 16] |
| paused | output | 1 | 1 while the controller is stopped |
| errFlag | output | 1 | Sticky flag for a data write refused while running |
| activeGroup | output | 8 | Current group pointer |

## Verification
The bench builds the block with NUM_CH set to 4. At that size it can write every byte of every time value and the status field of every channel, then compare the entire packed output buses against values computed arithmetically from the channel and slot indices. The small channel count leaves group values just above the last channel, such as 4 and 5, available as unimplemented groups. These can be tested alongside unused offsets and offset 4 in the top-level bank. The reserved action addresses are exercised with the pointer both on a channel and on the top-level group, so their decoding is shown not to depend on it.

// File: rtl/indir_regfile_pkg.sv
package indir_regfile_pkg;
  localparam int BYTE_W = 8;
  localparam int TIME_W = 2 * BYTE_W;
  localparam int STAT_W = 3;

  localparam logic [BYTE_W-1:0] ADDR_GRST  = 8'd135;
  localparam logic [BYTE_W-1:0] ADDR_STOP  = 8'd23;
  localparam logic [BYTE_W-1:0] ADDR_RUN   = 8'd31;
  localparam logic [BYTE_W-1:0] ADDR_GROUP = 8'd15;
  localparam logic [BYTE_W-1:0] GROUP_TOP  = 8'd64;
  localparam logic [BYTE_W-1:0] OFF_STATUS = 8'd4;
  localparam int               OFF_HIGH   = 128;

  typedef struct packed {
    logic              clrAll;
    logic              wrCh;
    logic              wrTop;
    logic [BYTE_W-1:0] grp;
    logic [BYTE_W-1:0] offset;
    logic [BYTE_W-1:0] data;
  } rfStrobe_t;
endpackage

// File: rtl/indir_regfile_ctrl.sv
module indir_regfile_ctrl
  import indir_regfile_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addrWr,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] hostByte,
  output rfStrobe_t         strb,
  output logic              paused,
  output logic              errFlag,
  output logic [BYTE_W-1:0] activeGroup
);
  localparam logic [BYTE_W:0] CH_LIMIT = (BYTE_W+1)'(NUM_CH);

  logic [BYTE_W-1:0] curAddr;
  logic addrIsAction, dataTake, grstNow, stopNow, runNow, grpIsCh, grpIsTop, cfgWrite;

  assign grstNow      = addrWr && (hostByte == ADDR_GRST);
  assign stopNow      = addrWr && (hostByte == ADDR_STOP);
  assign runNow       = addrWr && (hostByte == ADDR_RUN);
  assign addrIsAction = (curAddr == ADDR_GRST) || (curAddr == ADDR_STOP) || (curAddr == ADDR_RUN);
  assign dataTake     = dataWr && !addrWr && !addrIsAction;
  assign grpIsCh      = {1'b0, activeGroup} < CH_LIMIT;
  assign grpIsTop     = activeGroup == GROUP_TOP;
  assign cfgWrite     = dataTake && paused && (curAddr != ADDR_GROUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr     <= ADDR_GRST;
      paused      <= 1'b1;
      errFlag     <= 1'b0;
      activeGroup <= '0;
    end else begin
      if (addrWr) curAddr <= hostByte;
      if (grstNow) begin
        paused      <= 1'b1;
        errFlag     <= 1'b0;
        activeGroup <= '0;
      end else if (stopNow) begin
        paused <= 1'b1;
      end else if (runNow) begin
        paused <= 1'b0;
      end
      if (dataTake) begin
        if (!paused) errFlag <= 1'b1;
        else if (curAddr == ADDR_GROUP) activeGroup <= hostByte;
      end
    end
  end

  always_comb begin
    strb.clrAll = grstNow;
    strb.wrCh   = cfgWrite && grpIsCh;
    strb.wrTop  = cfgWrite && grpIsTop;
    strb.grp    = activeGroup;
    strb.offset = curAddr;
    strb.data   = hostByte;
  end

  p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addrWr && hostByte == ADDR_STOP) |=> paused);
  p_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addrWr && hostByte == ADDR_RUN) |=> !paused);
  p_grst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addrWr && hostByte == ADDR_GRST) |=> (paused && !errFlag && activeGroup == '0));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (errFlag && !(addrWr && hostByte == ADDR_GRST)) |=> errFlag);
  p_run_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !paused |-> !(strb.wrCh || strb.wrTop));
  p_ptr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && dataWr && !addrWr && curAddr == ADDR_GROUP) |=> activeGroup == $past(hostByte));
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!paused && !addrWr) |=> $stable(activeGroup));
endmodule

// File: rtl/indir_regfile_dp.sv
module indir_regfile_dp
  import indir_regfile_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int NUM_TIMES = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  rfStrobe_t                         strb,
  output logic [NUM_CH*NUM_TIMES*TIME_W-1:0] chTime,
  output logic [NUM_CH*STAT_W-1:0]          chStatus,
  output logic [NUM_TIMES*TIME_W-1:0]       topTime
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [BYTE_W-1:0] CH_ID = BYTE_W'(c);
    logic hit;
    assign hit = strb.wrCh && (strb.grp == CH_ID);

    for (genvar t = 0; t < NUM_TIMES; t++) begin : g_time
      localparam logic [BYTE_W-1:0] LO_OFF = BYTE_W'(t);
      localparam logic [BYTE_W-1:0] HI_OFF = BYTE_W'(OFF_HIGH + t);
      logic [TIME_W-1:0] timeQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            timeQ <= '0;
        else if (strb.clrAll)                  timeQ <= '0;
        else if (hit && strb.offset == LO_OFF) timeQ[BYTE_W-1:0] <= strb.data;
        else if (hit && strb.offset == HI_OFF) timeQ[TIME_W-1:BYTE_W] <= strb.data;
      end
      assign chTime[(c*NUM_TIMES+t)*TIME_W +: TIME_W] = timeQ;
    end

    logic [STAT_W-1:0] statQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                statQ <= '0;
      else if (strb.clrAll)                      statQ <= '0;
      else if (hit && strb.offset == OFF_STATUS) statQ <= strb.data[STAT_W-1:0];
    end
    assign chStatus[c*STAT_W +: STAT_W] = statQ;
  end

  for (genvar t = 0; t < NUM_TIMES; t++) begin : g_top
    localparam logic [BYTE_W-1:0] LO_OFF = BYTE_W'(t);
    localparam logic [BYTE_W-1:0] HI_OFF = BYTE_W'(OFF_HIGH + t);
    logic [TIME_W-1:0] timeQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   timeQ <= '0;
      else if (strb.clrAll)                         timeQ <= '0;
      else if (strb.wrTop && strb.offset == LO_OFF) timeQ[BYTE_W-1:0] <= strb.data;
      else if (strb.wrTop && strb.offset == HI_OFF) timeQ[TIME_W-1:BYTE_W] <= strb.data;
    end
    assign topTime[t*TIME_W +: TIME_W] = timeQ;
  end

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrAll |=> (chTime == '0 && chStatus == '0 && topTime == '0));
  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.wrCh && !strb.clrAll) |=> ($stable(chStatus) && $stable(chTime)));
  p_top_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.wrTop && !strb.clrAll) |=> $stable(topTime));
  p_one_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.wrCh && strb.wrTop));
endmodule

// File: rtl/indir_regfile.sv
module indir_regfile
  import indir_regfile_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int NUM_TIMES = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               addrWr,
  input  logic                               dataWr,
  input  logic [7:0]                         hostByte,
  output logic [NUM_CH*NUM_TIMES*16-1:0]     chTime,
  output logic [NUM_CH*3-1:0]                chStatus,
  output logic [NUM_TIMES*16-1:0]            topTime,
  output logic                               paused,
  output logic                               errFlag,
  output logic [7:0]                         activeGroup
);
  rfStrobe_t strb;

  indir_regfile_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .addrWr(addrWr), .dataWr(dataWr), .hostByte(hostByte),
    .strb(strb), .paused(paused), .errFlag(errFlag), .activeGroup(activeGroup)
  );

  indir_regfile_dp #(.NUM_CH(NUM_CH), .NUM_TIMES(NUM_TIMES)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .chTime(chTime), .chStatus(chStatus), .topTime(topTime)
  );
endmodule

// File: tb/indir_regfile_tb_top.sv
module indir_regfile_tb_top;
  localparam int NCH = 4;
  localparam int NT  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addrWr = 1'b0;
  logic dataWr = 1'b0;
  logic [7:0] hostByte = '0;
  logic [NCH*NT*16-1:0] chTime;
  logic [NCH*3-1:0] chStatus;
  logic [NT*16-1:0] topTime;
  logic paused, errFlag;
  logic [7:0] activeGroup;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [15:0] expT [NCH][NT];
  logic [2:0]  expS [NCH];
  logic [15:0] expTop [NT];

  always #10 clk = ~clk;

  indir_regfile #(.NUM_CH(NCH), .NUM_TIMES(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .addrWr(addrWr), .dataWr(dataWr), .hostByte(hostByte),
    .chTime(chTime), .chStatus(chStatus), .topTime(topTime),
    .paused(paused), .errFlag(errFlag), .activeGroup(activeGroup)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic aw(input logic [7:0] a);
    @(negedge clk); addrWr = 1'b1; hostByte = a;
    @(negedge clk); addrWr = 1'b0;
  endtask

  task automatic dw(input logic [7:0] d);
    @(negedge clk); dataWr = 1'b1; hostByte = d;
    @(negedge clk); dataWr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    aw(a); dw(d);
  endtask

  task automatic clearExp();
    for (int c = 0; c < NCH; c++) begin
      expS[c] = '0;
      for (int t = 0; t < NT; t++) expT[c][t] = '0;
    end
    for (int t = 0; t < NT; t++) expTop[t] = '0;
  endtask

  task automatic checkBanks(input string req);
    logic [NCH*NT*16-1:0] eT;
    logic [NCH*3-1:0] eS;
    logic [NT*16-1:0] eTop;
    for (int c = 0; c < NCH; c++) begin
      eS[c*3 +: 3] = expS[c];
      for (int t = 0; t < NT; t++) eT[(c*NT+t)*16 +: 16] = expT[c][t];
    end
    for (int t = 0; t < NT; t++) eTop[t*16 +: 16] = expTop[t];
    chk(chTime == eT, {req, " chTime"}, 256'(chTime), 256'(eT));
    chk(chStatus == eS, {req, " chStatus"}, 256'(chStatus), 256'(eS));
    chk(topTime == eTop, {req, " topTime"}, 256'(topTime), 256'(eTop));
  endtask

  task automatic checkCtl(input string req, input logic p, input logic e, input logic [7:0] g);
    chk(paused == p, {req, " paused"}, 256'(paused), 256'(p));
    chk(errFlag == e, {req, " errFlag"}, 256'(errFlag), 256'(e));
    chk(activeGroup == g, {req, " activeGroup"}, 256'(activeGroup), 256'(g));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    clearExp();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkCtl("R1", 1'b1, 1'b0, 8'd0);
    checkBanks("R1");

    // R4 R5 R6: full sweep of every channel byte and status field
    for (int c = 0; c < NCH; c++) begin
      wr(8'd15, 8'(c));
      chk(activeGroup == 8'(c), "R4 pointer load", 256'(activeGroup), 256'(c));
      for (int t = 0; t < NT; t++) begin
        logic [15:0] v;
        v = 16'((c*NT + t + 1) * 16'h0B13);
        wr(8'(t), v[7:0]);
        wr(8'(128 + t), v[15:8]);
        expT[c][t] = v;
      end
      wr(8'd4, 8'(c + 5) | 8'hF8);
      expS[c] = 3'((c + 5) & 7);
    end
    checkBanks("R5 R6 sweep");

    // R6 single status bit positions on channel 2
    wr(8'd15, 8'd2);
    for (int b = 0; b < 3; b++) begin
      wr(8'd4, 8'(1 << b));
      expS[2] = 3'(1 << b);
      chk(chStatus[2*3 +: 3] == 3'(1 << b), "R6 status bit", 256'(chStatus[2*3 +: 3]), 256'(1 << b));
    end

    // R7 top-level bank
    wr(8'd15, 8'd64);
    for (int t = 0; t < NT; t++) begin
      logic [15:0] v;
      v = 16'(16'hA000 + t * 16'h0111);
      wr(8'(128 + t), v[15:8]);
      wr(8'(t), v[7:0]);
      expTop[t] = v;
    end
    checkBanks("R7 top bank");

    // R9 unimplemented offsets and groups
    wr(8'd4, 8'h07);
    checkBanks("R9 top offset 4");
    for (int g = NCH; g < NCH + 2; g++) begin
      wr(8'd15, 8'(g));
      wr(8'd0, 8'h5A);
      wr(8'd128, 8'hA5);
      wr(8'd4, 8'h07);
    end
    checkBanks("R9 unimplemented group");
    wr(8'd15, 8'd1);
    wr(8'd5, 8'hFF);
    wr(8'd127, 8'hFF);
    wr(8'd132, 8'hFF);
    wr(8'd200, 8'hFF);
    checkBanks("R9 unused offsets");

    // R10 simultaneous strobes: data ignored, address taken
    aw(8'd0);
    @(negedge clk); addrWr = 1'b1; dataWr = 1'b1; hostByte = 8'd3;
    @(negedge clk); addrWr = 1'b0; dataWr = 1'b0;
    checkBanks("R10 both strobes");
    dw(8'h3C);
    expT[1][3][7:0] = 8'h3C;
    checkBanks("R10 address taken");

    // R3 R10 actions with pointer on the top group
    wr(8'd15, 8'd64);
    aw(8'd31);
    checkCtl("R3 run", 1'b0, 1'b0, 8'd64);
    dw(8'h12);
    checkCtl("R10 data after action", 1'b0, 1'b0, 8'd64);
    // R8 refused writes while running
    wr(8'd0, 8'h99);
    checkCtl("R8 err set", 1'b0, 1'b1, 8'd64);
    checkBanks("R8 no change");
    wr(8'd15, 8'd2);
    checkCtl("R8 pointer held", 1'b0, 1'b1, 8'd64);
    aw(8'd23);
    checkCtl("R3 stop", 1'b1, 1'b1, 8'd64);
    dw(8'h01);
    checkCtl("R10 R8 sticky after stop", 1'b1, 1'b1, 8'd64);
    checkBanks("R10 data after stop");

    // R3 R10 with pointer on a channel
    wr(8'd15, 8'd3);
    aw(8'd31);
    checkCtl("R3 run ch", 1'b0, 1'b1, 8'd3);
    aw(8'd23);
    checkCtl("R3 stop ch", 1'b1, 1'b1, 8'd3);

    // R2 global reset
    aw(8'd135);
    clearExp();
    checkCtl("R2", 1'b1, 1'b0, 8'd0);
    checkBanks("R2");
    dw(8'h44);
    checkBanks("R10 data after reset");
    // R2 reset from running state
    aw(8'd31);
    aw(8'd135);
    checkCtl("R2 from run", 1'b1, 1'b0, 8'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule